// File: doc/BRIEF.md
# Input Word Order Swapper

This stage sits in front of a hash message buffer and turns each 32-bit input word into the byte and bit order the hash core works in. Software writes its message as a little-endian string, and the unit lets it say how that string is built up: as whole words, as 16-bit half-words, as bytes or as single bits. A 2-bit mode chooses one of four fixed reorderings, so a little-endian stream arrives at the big-endian core already in the right order.

Each word comes with a valid strobe. The mode is sampled in the same cycle as the word. The reordered word and its strobe come out of a register one clock later. Between accepted words the output word keeps its last value. The unit does no padding, no length handling and no hashing.

Top module: `msg_word_swapper`

## Requirements
- R1: While the active-low reset rstN is low, outValid is 0 and outWord is all zeros.
- R2: outValid equals the value inValid had at the previous rising clock edge, so it is high for exactly one cycle per accepted word.
- R3: When dataMode is 2'b00 (word) with inValid high, outWord on the next cycle equals inWord unchanged.
- R4: When dataMode is 2'b01 (half-word) with inValid high, outWord on the next cycle is the input with its two 16-bit halves exchanged: out[31:16] = in[15:0] and out[15:0] = in[31:16].
- R5: When dataMode is 2'b10 (byte) with inValid high, outWord on the next cycle has the four bytes in reverse order: out[31:24] = in[7:0], out[23:16] = in[15:8], out[15:8] = in[23:16], out[7:0] = in[31:24].
- R6: When dataMode is 2'b11 (bit) with inValid high, outWord on the next cycle is the input with all bits reversed: out[i] = in[31-i] for every i.
- R7: In a cycle where inValid is low, inWord and dataMode have no effect: outWord keeps its previous value.
- R8: Words presented on back-to-back cycles are each reordered by the mode present in their own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input word strobe |
| inWord | input | 32 | Little-endian input word |
| dataMode | input | 2 | Data-type setting: 00 word, 01 half-word, 10 byte, 11 bit |
| outValid | output | 1 | Output word strobe, one clock after inValid |
| outWord | output | 32 | Reordered word |

## Verification
Every result has a latency of one clock. A word and its mode captured at a rising edge show up on outWord and outValid right after that edge, and an idle cycle shows up as outValid low with outWord held at the same point. The bench changes its inputs on the falling edge and reads the outputs at the next falling edge. That read falls half a period after the register updates and half a period before the next capture. The hold and back-to-back scenarios check each following falling edge in turn, so any extra or missing register stage shows up as a mismatch.

// File: rtl/swap_pkg.sv
package swap_pkg;

  typedef enum logic [1:0] {
    MODE_WORD = 2'b00,
    MODE_HALF = 2'b01,
    MODE_BYTE = 2'b10,
    MODE_BIT  = 2'b11
  } swap_mode_e;

  typedef struct packed {
    logic       load;
    swap_mode_e mode;
  } swap_ctrl_t;

endpackage

// File: rtl/swap_ctrl.sv
module swap_ctrl
  import swap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] dataMode,
  output swap_ctrl_t ctrl,
  output logic       outValid
);

  always_comb begin
    ctrl.load = inValid;
    ctrl.mode = swap_mode_e'(dataMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R1
  reset_valid_low_chk: assert property (@(posedge clk) !rstN |=> !outValid);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/swap_datapath.sv
module swap_datapath
  import swap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  swap_ctrl_t        ctrl,
  input  logic [WORD_W-1:0] inWord,
  output logic [WORD_W-1:0] outWord
);

  localparam int LANES  = WORD_W / LANE_W;
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] halfSwap;
  logic [WORD_W-1:0] laneRev;
  logic [WORD_W-1:0] bitRev;
  logic [WORD_W-1:0] nextWord;

  assign halfSwap = {inWord[HALF_W-1:0], inWord[WORD_W-1:HALF_W]};

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign laneRev[b*LANE_W +: LANE_W] = inWord[(LANES-1-b)*LANE_W +: LANE_W];
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign bitRev[i] = inWord[WORD_W-1-i];
  end

  always_comb begin
    unique case (ctrl.mode)
      MODE_WORD: nextWord = inWord;
      MODE_HALF: nextWord = halfSwap;
      MODE_BYTE: nextWord = laneRev;
      MODE_BIT:  nextWord = bitRev;
      default:   nextWord = inWord;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          outWord <= '0;
    else if (ctrl.load) outWord <= nextWord;
  end

  // R1
  reset_word_zero_chk: assert property (@(posedge clk) !rstN |=> (outWord == '0));

  // R3
  word_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.mode == MODE_WORD) |=> (outWord == $past(inWord)));

  // R4
  half_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.mode == MODE_HALF) |=>
      (outWord[HALF_W-1:0] == $past(inWord[WORD_W-1:HALF_W]) &&
       outWord[WORD_W-1:HALF_W] == $past(inWord[HALF_W-1:0])));

  // R5
  byte_rev_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.mode == MODE_BYTE) |=>
      (outWord[LANE_W-1:0] == $past(inWord[WORD_W-1 -: LANE_W]) &&
       outWord[WORD_W-1 -: LANE_W] == $past(inWord[LANE_W-1:0])));

  // R6
  bit_rev_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.mode == MODE_BIT) |=>
      (outWord[0] == $past(inWord[WORD_W-1]) &&
       outWord[WORD_W-1] == $past(inWord[0])));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(outWord));

endmodule

// File: rtl/msg_word_swapper.sv
module msg_word_swapper
  import swap_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic [1:0]        dataMode,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord
);

  swap_ctrl_t ctrl;

  swap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .dataMode (dataMode),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  swap_datapath #(
    .WORD_W (WORD_W),
    .LANE_W (8)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .inWord  (inWord),
    .outWord (outWord)
  );

endmodule

// File: tb/msg_word_swapper_bench.sv
module msg_word_swapper_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic [1:0]  dataMode = 2'b00;
  logic        outValid;
  logic [31:0] outWord;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  msg_word_swapper u_msg_word_swapper (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inWord   (inWord),
    .dataMode (dataMode),
    .outValid (outValid),
    .outWord  (outWord)
  );

  function automatic logic [31:0] refOrder(input logic [31:0] w, input logic [1:0] m);
    logic [31:0] r;
    case (m)
      2'b00: r = w;
      2'b01: r = {w[15:0], w[31:16]};
      2'b10: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      default: begin
        for (int i = 0; i < 32; i++) r[i] = w[31 - i];
      end
    endcase
    return r;
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] w, input logic [1:0] m);
    inValid  = v;
    inWord   = w;
    dataMode = m;
  endtask

  // Drive one word, check it at the following falling edge.
  task automatic sendAndCheck(input string req, input logic [31:0] w, input logic [1:0] m);
    @(negedge clk);
    drive(1'b1, w, m);
    @(negedge clk);
    drive(1'b0, 32'h0, 2'b00);
    checkVal(req, "outValid", {31'b0, outValid}, 32'd1);
    checkVal(req, "outWord", outWord, refOrder(w, m));
  endtask

  task automatic testReset;
    @(negedge clk);
    checkVal("R1", "outValid in reset", {31'b0, outValid}, 32'd0);
    checkVal("R1", "outWord in reset", outWord, 32'h0);
    drive(1'b1, 32'hDEADBEEF, 2'b11);
    @(negedge clk);
    checkVal("R1", "outValid with strobe in reset", {31'b0, outValid}, 32'd0);
    checkVal("R1", "outWord with strobe in reset", outWord, 32'h0);
    drive(1'b0, 32'h0, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R2", "outValid idle after reset", {31'b0, outValid}, 32'd0);
  endtask

  task automatic testWord;
    sendAndCheck("R3", 32'h12345678, 2'b00);
    sendAndCheck("R3", 32'hF0E1D2C3, 2'b00);
  endtask

  task automatic testHalf;
    sendAndCheck("R4", 32'h12345678, 2'b01);
    checkVal("R4", "explicit half swap", outWord, 32'h56781234);
    sendAndCheck("R4", 32'hFFFF0000, 2'b01);
  endtask

  task automatic testByte;
    sendAndCheck("R5", 32'h12345678, 2'b10);
    checkVal("R5", "explicit byte reverse", outWord, 32'h78563412);
    sendAndCheck("R5", 32'hA1B2C3D4, 2'b10);
  endtask

  task automatic testBit;
    sendAndCheck("R6", 32'h00000001, 2'b11);
    checkVal("R6", "explicit bit reverse", outWord, 32'h80000000);
    sendAndCheck("R6", 32'h12345678, 2'b11);
    checkVal("R6", "explicit bit reverse 2", outWord, 32'h1E6A2C48);
  endtask

  task automatic testHold;
    logic [31:0] held;
    sendAndCheck("R7", 32'hCAFEF00D, 2'b10);
    held = outWord;
    drive(1'b0, 32'h11111111, 2'b11);
    @(negedge clk);
    checkVal("R7", "outWord held idle", outWord, held);
    checkVal("R2", "outValid low idle", {31'b0, outValid}, 32'd0);
    drive(1'b0, 32'h87654321, 2'b01);
    @(negedge clk);
    checkVal("R7", "outWord held second idle", outWord, held);
  endtask

  task automatic testBackToBack;
    logic [31:0] words [4];
    words[0] = 32'h01234567;
    words[1] = 32'h89ABCDEF;
    words[2] = 32'h0F1E2D3C;
    words[3] = 32'h80000001;
    @(negedge clk);
    drive(1'b1, words[0], 2'b00);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      checkVal("R8", "b2b outWord", outWord, refOrder(words[k-1], 2'(k - 1)));
      checkVal("R2", "b2b outValid", {31'b0, outValid}, 32'd1);
      drive(1'b1, words[k], 2'(k));
    end
    @(negedge clk);
    checkVal("R8", "b2b last outWord", outWord, refOrder(words[3], 2'b11));
    drive(1'b0, 32'h0, 2'b00);
    @(negedge clk);
    checkVal("R2", "outValid drops after burst", {31'b0, outValid}, 32'd0);
  endtask

  initial begin
    #(8 * 5000);
    if (!finished) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    testReset();
    testWord();
    testHalf();
    testByte();
    testBit();
    testHold();
    testBackToBack();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule